// File: doc/BRIEF.md
# Strap-Addressed I2C Command and Status Slave

This block is the host-facing end of a command processor. It listens on a two-wire I2C bus as a slave only: the host owns SCL and starts every transfer, at standard (100 kbit/s) or fast (400 kbit/s) rate. Each byte that a matching host writes is handed to the command logic through a one-cycle valid strobe. Each byte that the host reads is a status byte built from a 2-bit code that the command logic supplies.

The 7-bit bus address has five fixed upper bits (binary 00111). The two lowest address bits come from two strap pins, so up to four of these slaves can share one bus. SDA is open drain. The block never drives it high. It only asserts an enable that pulls the line low, for its own acknowledge and for the zero bits of read data. SCL is an input only. Both bus lines are resynchronised into the system clock, and bus edges, START and STOP are found by oversampling. The system clock must therefore run at least ten times faster than SCL.

Top module: `i2c_cmd_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low in the ninth clock) an address byte only when its upper seven bits equal binary 00111, then strap_a2, then strap_a1. Bit 0 of the address byte is the direction: 0 write, 1 read.
- R2: After an address that does not match, sda_oe stays low and cmd_valid never pulses until the next START or STOP, whatever the host sends.
- R3: In a write transfer, each data byte (received MSB first) appears on cmd_data together with a single-cycle cmd_valid pulse and is acknowledged.
- R4: A read returns the byte 0x80 plus status_code: code 0 gives 0x80 (accepted), 1 gives 0x81 (error), 2 gives 0x82 (processing) and 3 gives 0x83 (not ready). It is sent MSB first, with a 0 bit driven low and a 1 bit released.
- R5: During a read, a host ACK makes the slave load status_code again for the next byte. A host NACK makes the slave release SDA and drive nothing until the next START or STOP.
- R6: A repeated START at any point restarts address reception, and the new address byte is judged afresh.
- R7: A STOP releases SDA and returns the slave to idle.
- R8: After reset, sda_oe and cmd_valid are low. sda_oe changes only while the synchronised SCL is low, or right after a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_a2 | input | 1 | Address bit 2 strap |
| strap_a1 | input | 1 | Address bit 1 strap |
| status_code | input | 2 | Status selector from the command logic |
| cmd_valid | output | 1 | One-cycle strobe for a received command byte |
| cmd_data | output | 8 | Received command byte |

## Verification
The hardest case to reach from the ports is the status reload between two read bytes. The code must be taken at the host's acknowledge and not at the start of the transfer. To reach it, the bench changes status_code in the gap between the address acknowledge and the host ACK of the first byte, then checks that the two bytes differ. The silent states are exercised the same way. The bench clocks a full byte of zeros after an address mismatch and after a host NACK, while a per-cycle monitor flags any pull-down. A repeated START is issued both in the middle of a write and right after a mismatched address.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_SKIP
   } slv_state_t;

   typedef struct packed {
      logic scl;
      logic sda;
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
   } bus_ev_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_line_sync: STAGES must be at least 2");
      end
      for (genvar g = 0; g < WIDTH; g++) begin : g_line
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], din[g]};
         end
         assign dout[g] = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond
   import i2c_cmd_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_s,
   input  logic    sda_s,
   output bus_ev_t ev
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_comb begin
      ev.scl      = scl_s;
      ev.sda      = sda_s;
      ev.scl_rise = scl_s & ~scl_q;
      ev.scl_fall = ~scl_s & scl_q;
      ev.start    = scl_s & scl_q & sda_q & ~sda_s;
      ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
   end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
   import i2c_cmd_pkg::*;
#(
   parameter int               BYTE_W      = 8,
   parameter logic [4:0]       ADDR_FIXED  = 5'b00111,
   parameter logic [BYTE_W-1:0] STATUS_BASE = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_ev_t           ev,
   input  logic              strap_a2,
   input  logic              strap_a1,
   input  logic [1:0]        status_code,
   output logic              sda_oe,
   output logic              cmd_valid,
   output logic [BYTE_W-1:0] cmd_data
);
   localparam int ADDR_W = BYTE_W - 1;
   localparam int CNT_W  = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

   generate
      if (BYTE_W != 8) begin : g_bad_width
         $error("i2c_slave_fsm: I2C bytes are 8 bits wide");
      end
   endgenerate

   slv_state_t        state;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] rx_sr, tx_sr;
   logic              rw_flag, host_ack;
   logic [ADDR_W-1:0] my_addr;
   logic [BYTE_W-1:0] status_byte;

   assign my_addr     = {ADDR_FIXED, strap_a2, strap_a1};
   assign status_byte = STATUS_BASE | {{(BYTE_W-2){1'b0}}, status_code};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bit_cnt   <= '0;
         rx_sr     <= '0;
         tx_sr     <= '0;
         rw_flag   <= 1'b0;
         host_ack  <= 1'b0;
         sda_oe    <= 1'b0;
         cmd_valid <= 1'b0;
         cmd_data  <= '0;
      end else begin
         cmd_valid <= 1'b0;
         if (ev.start) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else if (ev.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_WR: begin
                  if (ev.scl_rise && bit_cnt < FULL) begin
                     rx_sr   <= {rx_sr[BYTE_W-2:0], ev.sda};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (ev.scl_fall && bit_cnt == FULL) begin
                     if (state == ST_ADDR) begin
                        if (rx_sr[BYTE_W-1:1] == my_addr) begin
                           sda_oe  <= 1'b1;
                           rw_flag <= rx_sr[0];
                           state   <= ST_ADDR_ACK;
                        end else begin
                           state <= ST_SKIP;
                        end
                     end else begin
                        sda_oe    <= 1'b1;
                        cmd_valid <= 1'b1;
                        cmd_data  <= rx_sr;
                        state     <= ST_WR_ACK;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (ev.scl_fall) begin
                     bit_cnt <= '0;
                     if (rw_flag) begin
                        tx_sr  <= status_byte;
                        sda_oe <= ~status_byte[BYTE_W-1];
                        state  <= ST_RD;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_WR;
                     end
                  end
               end
               ST_WR_ACK: begin
                  if (ev.scl_fall) begin
                     sda_oe  <= 1'b0;
                     bit_cnt <= '0;
                     state   <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (ev.scl_rise) begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (ev.scl_fall) begin
                     if (bit_cnt == FULL) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RD_ACK;
                     end else begin
                        tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~tx_sr[BYTE_W-2];
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (ev.scl_rise) begin
                     host_ack <= ~ev.sda;
                  end else if (ev.scl_fall) begin
                     if (host_ack) begin
                        tx_sr   <= status_byte;
                        sda_oe  <= ~status_byte[BYTE_W-1];
                        bit_cnt <= '0;
                        state   <= ST_RD;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R1: the acknowledge phase is only entered for our own address
   a_r1_ack_own_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR_ACK) |-> (rx_sr[BYTE_W-1:1] == my_addr));
   // R2: silent state keeps the line released
   a_r2_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP && !ev.start) |=> !sda_oe);
   // R3: each command byte gives one single-cycle strobe
   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);
   // R7: STOP releases the line and idles
   a_r7_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      ev.stop |=> (!sda_oe && state == ST_IDLE));
   // R8: drive changes only with SCL low or after a bus condition
   a_r8_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> (!ev.scl || $past(ev.start || ev.stop)));
endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave
   import i2c_cmd_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [4:0] ADDR_FIXED  = 5'b00111
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic       strap_a2,
   input  logic       strap_a1,
   input  logic [1:0] status_code,
   output logic       cmd_valid,
   output logic [7:0] cmd_data
);
   localparam int BYTE_W = 8;

   logic [1:0] lines_s;
   bus_ev_t    ev;

   i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({scl_i, sda_i}),
      .dout (lines_s)
   );

   i2c_bus_cond u_cond (
      .clk  (clk),
      .rst_n(rst_n),
      .scl_s(lines_s[1]),
      .sda_s(lines_s[0]),
      .ev   (ev)
   );

   i2c_slave_fsm #(
      .BYTE_W     (BYTE_W),
      .ADDR_FIXED (ADDR_FIXED),
      .STATUS_BASE(8'h80)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev         (ev),
      .strap_a2   (strap_a2),
      .strap_a1   (strap_a1),
      .status_code(status_code),
      .sda_oe     (sda_oe),
      .cmd_valid  (cmd_valid),
      .cmd_data   (cmd_data)
   );
endmodule

// File: tb/i2c_cmd_slave_test.sv
module i2c_cmd_slave_test;
   localparam int CLK_P = 10;
   localparam int HALF  = 20;
   localparam int QTR   = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1, m_sda = 1'b1;
   logic       a2 = 1'b0, a1 = 1'b0;
   logic [1:0] code = 2'd0;
   logic       sda_oe, cmd_valid;
   logic [7:0] cmd_data;
   logic       sda_line;

   assign sda_line = m_sda & ~sda_oe;
   always #(CLK_P/2) clk = ~clk;

   i2c_cmd_slave uut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
      .strap_a2(a2), .strap_a1(a1), .status_code(code),
      .cmd_valid(cmd_valid), .cmd_data(cmd_data)
   );

   int  checks = 0, failures = 0, quiet_err = 0;
   bit  quiet = 1'b0, done = 1'b0;
   logic [7:0] got_q[$];
   logic [7:0] exp_q[$];

   // per-clock reference monitor: no pull-down in silent windows, strobes collected
   always @(negedge clk) begin
      if (quiet && sda_oe) quiet_err++;
      if (cmd_valid) got_q.push_back(cmd_data);
   end

   function automatic bit addr_hits(input logic [6:0] a);
      return a == {5'b00111, a2, a1};
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic m_start();
      m_sda = 1'b1; idle(QTR);
      m_scl = 1'b1; idle(HALF);
      m_sda = 1'b0; idle(HALF);
      m_scl = 1'b0; idle(QTR);
   endtask

   task automatic m_stop();
      m_sda = 1'b0; idle(QTR);
      m_scl = 1'b1; idle(HALF);
      m_sda = 1'b1; idle(HALF);
   endtask

   task automatic m_bit(input bit b, output bit s);
      m_sda = b; idle(QTR);
      m_scl = 1'b1; idle(HALF/2);
      s = sda_line; idle(HALF/2);
      m_scl = 1'b0; idle(QTR);
   endtask

   task automatic m_wbyte(input logic [7:0] v, output bit acked);
      bit s;
      for (int i = 7; i >= 0; i--) m_bit(v[i], s);
      m_bit(1'b1, s);
      acked = !s;
   endtask

   task automatic m_rbyte(output logic [7:0] v, input bit give_ack);
      bit s;
      for (int i = 7; i >= 0; i--) begin
         m_bit(1'b1, s);
         v[i] = s;
      end
      m_bit(!give_ack, s);
   endtask

   task automatic check_cmds(input string tag);
      chk(got_q.size() == exp_q.size(), tag, got_q.size(), exp_q.size());
      while (got_q.size() > 0 && exp_q.size() > 0) begin
         logic [7:0] g, e;
         g = got_q.pop_front();
         e = exp_q.pop_front();
         chk(g == e, tag, g, e);
      end
      got_q.delete();
      exp_q.delete();
   endtask

   initial begin
      #(CLK_P * 190000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      bit ack;
      logic [7:0] rd;
      idle(3);
      rst_n = 1'b1;
      idle(5);
      // R8: reset state
      chk(sda_oe == 1'b0, "R8 reset sda_oe", sda_oe, 0);
      chk(cmd_valid == 1'b0, "R8 reset cmd_valid", cmd_valid, 0);

      // R1 R3: write two command bytes to 0x1C
      m_start();
      m_wbyte({7'h1C, 1'b0}, ack);
      chk(ack == addr_hits(7'h1C), "R1 own address ack", ack, 1);
      m_wbyte(8'hA5, ack); exp_q.push_back(8'hA5);
      chk(ack, "R3 data ack", ack, 1);
      m_wbyte(8'h3C, ack); exp_q.push_back(8'h3C);
      chk(ack, "R3 data ack", ack, 1);
      m_stop();
      idle(6);
      chk(sda_oe == 1'b0, "R7 released after stop", sda_oe, 0);
      check_cmds("R3 command bytes");

      // R2: mismatched address, then a byte of zeros
      quiet = 1'b1;
      m_start();
      m_wbyte({7'h1D, 1'b0}, ack);
      chk(ack == addr_hits(7'h1D), "R2 foreign address nack", ack, 0);
      m_wbyte(8'h00, ack);
      chk(!ack, "R2 data ignored", ack, 0);
      m_stop();
      idle(6);
      quiet = 1'b0;
      chk(quiet_err == 0, "R2 no drive after mismatch", quiet_err, 0);
      check_cmds("R2 no command strobe");

      // R1: straps move the address to 0x1E
      a2 = 1'b1; a1 = 1'b0; idle(4);
      m_start();
      m_wbyte({7'h1C, 1'b0}, ack);
      chk(!ack, "R1 old address rejected", ack, 0);
      m_stop();
      m_start();
      m_wbyte({7'h1E, 1'b0}, ack);
      chk(ack == addr_hits(7'h1E), "R1 strapped address ack", ack, 1);
      m_stop();

      // R4: every status code, single-byte reads
      for (int c = 0; c < 4; c++) begin
         code = 2'(c);
         m_start();
         m_wbyte({7'h1E, 1'b1}, ack);
         chk(ack, "R4 read address ack", ack, 1);
         m_rbyte(rd, 1'b0);
         chk(rd == (8'h80 | 8'(c)), "R4 status byte", rd, 8'h80 | c);
         m_stop();
      end

      // R5: reload on host ACK, release on NACK
      code = 2'd2;
      m_start();
      m_wbyte({7'h1E, 1'b1}, ack);
      code = 2'd3;
      m_rbyte(rd, 1'b1);
      chk(rd == 8'h82, "R5 first byte", rd, 8'h82);
      m_rbyte(rd, 1'b0);
      chk(rd == 8'h83, "R5 reloaded byte", rd, 8'h83);
      quiet = 1'b1;
      m_wbyte(8'h00, ack);
      quiet = 1'b0;
      chk(quiet_err == 0, "R5 released after nack", quiet_err, 0);
      m_stop();

      // R6: repeated start in a write, then turn to read
      code = 2'd1;
      m_start();
      m_wbyte({7'h1E, 1'b0}, ack);
      m_wbyte(8'h11, ack); exp_q.push_back(8'h11);
      m_start();
      m_wbyte({7'h1E, 1'b1}, ack);
      chk(ack, "R6 restart address ack", ack, 1);
      m_rbyte(rd, 1'b0);
      chk(rd == 8'h81, "R6 read after restart", rd, 8'h81);
      m_stop();
      check_cmds("R6 write before restart");

      // R6: repeated start rescues a mismatched transfer
      m_start();
      m_wbyte({7'h10, 1'b0}, ack);
      chk(!ack, "R6 foreign before restart", ack, 0);
      m_start();
      m_wbyte({7'h1E, 1'b0}, ack);
      chk(ack, "R6 own after restart", ack, 1);
      m_wbyte(8'h5A, ack); exp_q.push_back(8'h5A);
      m_stop();
      idle(6);
      chk(sda_oe == 1'b0, "R7 idle release", sda_oe, 0);
      check_cmds("R6 write after restart");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule